// File: doc/BRIEF.md
# Guest Entry State Checker

This block decides whether a request to enter a virtual machine carries a legal guest control state. The host side presents the candidate values on its inputs: the extended-feature register, CR0, CR3, CR4, DR6, DR7, the code-segment long-mode and default-size attribute bits, a capability bit that says whether the processor supports long mode, the address-space identifier, two permission-map base addresses and the physical address width. The host then pulses `start_i` for one cycle.

At that clock edge the block samples the inputs and evaluates fourteen independent legality rules. These cover paging mode, reserved bits, address width, the address-space identifier and the permission-map ranges. One cycle later it reports a single verdict. `entry_ok_o` pulses when every rule passes. `entry_bad_o` pulses when at least one rule fails. `fail_vec_o` carries one bit per rule and keeps the last verdict until the next start. Fetching the values from memory is left to the surrounding logic.

Top module: `guest_entry_checker`

## Requirements
- R1: The entry fails if the virtualization-enable bit (bit 12 of the extended-feature register) is clear, reported in fail bit 0. It also fails if any bit of that register set in the reserved mask (default 64'hFFFF_FFFF_FFFF_02FE) is one, reported in fail bit 1.
- R2: The entry fails (fail bit 2) if long-mode enable (bit 8) or long-mode active (bit 10) of the extended-feature register is set while `lm_cap_i` is low.
- R3: When long-mode enable and CR0.PG (bit 31) are both set, the entry fails if CR4.PAE (bit 5) is clear (fail bit 3), and it fails if CR0.PE (bit 0) is clear (fail bit 4).
- R4: When long-mode enable, CR0.PG and CR4.PAE are all set, the entry fails (fail bit 5) if `cs_long_i` and `cs_dflt_i` are both high.
- R5: The entry fails if CR0 has any bit set in its reserved mask (default: bits 63..32), reported in fail bit 6. It also fails if CR0.NW (bit 29) is set while CR0.CD (bit 30) is clear, reported in fail bit 7.
- R6: While long-mode active is set, the entry fails (fail bit 8) if CR3 has any bit set at or above bit position `pa_width_i`. When long-mode active is clear, this rule does not apply.
- R7: The entry fails (fail bit 9) if `asid_i` is zero.
- R8: The entry fails if DR6 has a bit set in the debug reserved mask (default: bits 63..32), reported in fail bit 10. It fails in the same way for DR7, reported in fail bit 11.
- R9: Map A (default 8192 bytes) fails (fail bit 12) if its base with bits 11..0 cleared is not below 2^`pa_width_i` minus its size. Map B (default 12288 bytes) is checked the same way and fails in fail bit 13.
- R10: In the cycle after a start pulse, exactly one of `entry_ok_o` and `entry_bad_o` is high, for one cycle. Neither output is high in any cycle that does not follow a start pulse.
- R11: `fail_vec_o` sets every failing rule's bit at once, is zero on a legal entry, is cleared by reset, and holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to evaluate the presented state |
| xfeat_i | input | 64 | Extended-feature register |
| cr0_i | input | 64 | Candidate CR0 |
| cr3_i | input | 64 | Candidate CR3 |
| cr4_i | input | 64 | Candidate CR4 |
| dr6_i | input | 64 | Candidate DR6 |
| dr7_i | input | 64 | Candidate DR7 |
| cs_long_i | input | 1 | Code-segment long-mode attribute |
| cs_dflt_i | input | 1 | Code-segment default-size attribute |
| lm_cap_i | input | 1 | Long mode supported |
| asid_i | input | 32 | Address-space identifier |
| map_a_base_i | input | 64 | Base address of permission map A |
| map_b_base_i | input | 64 | Base address of permission map B |
| pa_width_i | input | 6 | Physical address width, 32 to 52 |
| entry_ok_o | output | 1 | Pulse: entry legal |
| entry_bad_o | output | 1 | Pulse: entry illegal |
| fail_vec_o | output | 14 | One bit per failed rule, held until the next start |

## Verification
All three results are registered at the clock edge that samples `start_i`. They are therefore due one full cycle after the start pulse is driven. The bench drives `start_i` on a falling edge and samples the outputs on the following falling edge. It then waits one more cycle and confirms two things: both pulses have dropped, and the fail vector has held its value. Each scenario states its expected vector as a literal derived from the bit numbering in the requirements. Boundary pairs exercise the width and map comparisons on both sides of each limit.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

  localparam int unsigned XLEN      = 64;
  localparam int unsigned WID_BITS  = 6;
  localparam int unsigned NUM_RULES = 14;
  localparam int unsigned NUM_MAPS  = 2;

  // Position of each rule in the failure vector (bench and users decode it)
  localparam int unsigned RI_VIRT_OFF   = 0;
  localparam int unsigned RI_XF_RSVD    = 1;
  localparam int unsigned RI_LM_NOCAP   = 2;
  localparam int unsigned RI_NO_PAE     = 3;
  localparam int unsigned RI_NO_PE      = 4;
  localparam int unsigned RI_CS_LD      = 5;
  localparam int unsigned RI_CR0_RSVD   = 6;
  localparam int unsigned RI_NW_NOCD    = 7;
  localparam int unsigned RI_CR3_WIDE   = 8;
  localparam int unsigned RI_ASID_ZERO  = 9;
  localparam int unsigned RI_DR6_RSVD   = 10;
  localparam int unsigned RI_DR7_RSVD   = 11;
  localparam int unsigned RI_MAP_BASE   = 12;  // map g sits at RI_MAP_BASE + g

  localparam int unsigned MODE_RULES = 8;      // bits 0..7
  localparam int unsigned ADDR_RULES = NUM_RULES - MODE_RULES;

  localparam logic [XLEN-1:0] PAGE_OFS = 64'h0000_0000_0000_0FFF;

  // Mask of all bit positions at or above the given width
  function automatic logic [XLEN-1:0] bits_at_or_above(input logic [WID_BITS-1:0] w);
    logic [XLEN-1:0] one_hot;
    one_hot = 64'd1 << w;
    return ~(one_hot - 64'd1);
  endfunction

  // True when a page-aligned map base leaves too little room for the map
  function automatic logic map_past_limit(input logic [XLEN-1:0]     base,
                                          input logic [WID_BITS-1:0] w,
                                          input logic [XLEN-1:0]     size);
    logic [XLEN-1:0] top;
    logic [XLEN-1:0] page;
    top  = (64'd1 << w) - size;
    page = base & ~PAGE_OFS;
    return page >= top;
  endfunction

endpackage

// File: rtl/gsc_mode_rules.sv
module gsc_mode_rules
  import gsc_pkg::*;
#(
  parameter logic [XLEN-1:0] XF_RSVD_MASK  = 64'hFFFF_FFFF_FFFF_02FE,
  parameter logic [XLEN-1:0] CR0_RSVD_MASK = 64'hFFFF_FFFF_0000_0000,
  parameter int unsigned     XF_LME_BIT    = 8,
  parameter int unsigned     XF_LMA_BIT    = 10,
  parameter int unsigned     XF_VE_BIT     = 12
) (
  input  logic [XLEN-1:0]       xfeat,
  input  logic [XLEN-1:0]       cr0,
  input  logic                  pae,
  input  logic                  cs_long,
  input  logic                  cs_dflt,
  input  logic                  lm_cap,
  output logic [MODE_RULES-1:0] fail
);

  localparam int unsigned CR0_PE_BIT = 0;
  localparam int unsigned CR0_NW_BIT = 29;
  localparam int unsigned CR0_CD_BIT = 30;
  localparam int unsigned CR0_PG_BIT = 31;

  logic lme, lma, paged_long, long_pae;

  assign lme        = xfeat[XF_LME_BIT];
  assign lma        = xfeat[XF_LMA_BIT];
  assign paged_long = lme & cr0[CR0_PG_BIT];
  assign long_pae   = paged_long & pae;

  always_comb begin
    fail                = '0;
    fail[RI_VIRT_OFF]   = ~xfeat[XF_VE_BIT];
    fail[RI_XF_RSVD]    = |(xfeat & XF_RSVD_MASK);
    fail[RI_LM_NOCAP]   = (lme | lma) & ~lm_cap;
    fail[RI_NO_PAE]     = paged_long & ~pae;
    fail[RI_NO_PE]      = paged_long & ~cr0[CR0_PE_BIT];
    fail[RI_CS_LD]      = long_pae & cs_long & cs_dflt;
    fail[RI_CR0_RSVD]   = |(cr0 & CR0_RSVD_MASK);
    fail[RI_NW_NOCD]    = cr0[CR0_NW_BIT] & ~cr0[CR0_CD_BIT];
  end

endmodule

// File: rtl/gsc_addr_rules.sv
module gsc_addr_rules
  import gsc_pkg::*;
#(
  parameter logic [XLEN-1:0] DR_RSVD_MASK = 64'hFFFF_FFFF_0000_0000,
  parameter logic [XLEN-1:0] MAPA_BYTES   = 64'd8192,
  parameter logic [XLEN-1:0] MAPB_BYTES   = 64'd12288
) (
  input  logic                  lma,
  input  logic [XLEN-1:0]       cr3,
  input  logic [31:0]           asid,
  input  logic [XLEN-1:0]       dr6,
  input  logic [XLEN-1:0]       dr7,
  input  logic [XLEN-1:0]       map_a_base,
  input  logic [XLEN-1:0]       map_b_base,
  input  logic [WID_BITS-1:0]   pa_width,
  output logic [ADDR_RULES-1:0] fail
);

  localparam int unsigned OFS = MODE_RULES;

  logic [XLEN-1:0] bases [NUM_MAPS];
  logic [NUM_MAPS-1:0] map_bad;

  assign bases[0] = map_a_base;
  assign bases[1] = map_b_base;

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    localparam logic [XLEN-1:0] SZ = (g == 0) ? MAPA_BYTES : MAPB_BYTES;
    assign map_bad[g] = map_past_limit(bases[g], pa_width, SZ);
  end

  always_comb begin
    fail                         = '0;
    fail[RI_CR3_WIDE  - OFS]     = lma & (|(cr3 & bits_at_or_above(pa_width)));
    fail[RI_ASID_ZERO - OFS]     = (asid == 32'd0);
    fail[RI_DR6_RSVD  - OFS]     = |(dr6 & DR_RSVD_MASK);
    fail[RI_DR7_RSVD  - OFS]     = |(dr7 & DR_RSVD_MASK);
    for (int m = 0; m < NUM_MAPS; m++) begin
      fail[RI_MAP_BASE - OFS + m] = map_bad[m];
    end
  end

endmodule

// File: rtl/gsc_verdict_reg.sv
module gsc_verdict_reg
  import gsc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_RULES-1:0] fail_now,
  output logic                 ok,
  output logic                 bad,
  output logic [NUM_RULES-1:0] fail_vec
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok       <= 1'b0;
      bad      <= 1'b0;
      fail_vec <= '0;
    end else if (start) begin
      ok       <= (fail_now == '0);
      bad      <= (fail_now != '0);
      fail_vec <= fail_now;
    end else begin
      ok       <= 1'b0;
      bad      <= 1'b0;
    end
  end

  // R10: one verdict pulse per start, never both
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ok ^ bad));
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!ok && !bad));
  // R11: vector agrees with the verdict and holds between starts
  p_ok_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (fail_vec == '0));
  p_bad_marked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> (fail_vec != '0));
  p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(fail_vec));

endmodule

// File: rtl/guest_entry_checker.sv
module guest_entry_checker
  import gsc_pkg::*;
#(
  parameter logic [XLEN-1:0] XF_RSVD_MASK  = 64'hFFFF_FFFF_FFFF_02FE,
  parameter logic [XLEN-1:0] CR0_RSVD_MASK = 64'hFFFF_FFFF_0000_0000,
  parameter logic [XLEN-1:0] DR_RSVD_MASK  = 64'hFFFF_FFFF_0000_0000,
  parameter logic [XLEN-1:0] MAPA_BYTES    = 64'd8192,
  parameter logic [XLEN-1:0] MAPB_BYTES    = 64'd12288
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [63:0]          xfeat_i,
  input  logic [63:0]          cr0_i,
  input  logic [63:0]          cr3_i,
  input  logic [63:0]          cr4_i,
  input  logic [63:0]          dr6_i,
  input  logic [63:0]          dr7_i,
  input  logic                 cs_long_i,
  input  logic                 cs_dflt_i,
  input  logic                 lm_cap_i,
  input  logic [31:0]          asid_i,
  input  logic [63:0]          map_a_base_i,
  input  logic [63:0]          map_b_base_i,
  input  logic [5:0]           pa_width_i,
  output logic                 entry_ok_o,
  output logic                 entry_bad_o,
  output logic [13:0]          fail_vec_o
);

  localparam int unsigned LME_BIT    = 8;
  localparam int unsigned LMA_BIT    = 10;
  localparam int unsigned VE_BIT     = 12;
  localparam int unsigned CR4_PAE    = 5;

  logic [MODE_RULES-1:0] mode_fail;
  logic [ADDR_RULES-1:0] addr_fail;
  logic [NUM_RULES-1:0]  fail_now;
  logic                  unused_cr4_rest;

  assign unused_cr4_rest = ^{cr4_i[63:CR4_PAE+1], cr4_i[CR4_PAE-1:0]};

  gsc_mode_rules #(
    .XF_RSVD_MASK  (XF_RSVD_MASK),
    .CR0_RSVD_MASK (CR0_RSVD_MASK),
    .XF_LME_BIT    (LME_BIT),
    .XF_LMA_BIT    (LMA_BIT),
    .XF_VE_BIT     (VE_BIT)
  ) u_mode (
    .xfeat   (xfeat_i),
    .cr0     (cr0_i),
    .pae     (cr4_i[CR4_PAE]),
    .cs_long (cs_long_i),
    .cs_dflt (cs_dflt_i),
    .lm_cap  (lm_cap_i),
    .fail    (mode_fail)
  );

  gsc_addr_rules #(
    .DR_RSVD_MASK (DR_RSVD_MASK),
    .MAPA_BYTES   (MAPA_BYTES),
    .MAPB_BYTES   (MAPB_BYTES)
  ) u_addr (
    .lma        (xfeat_i[LMA_BIT]),
    .cr3        (cr3_i),
    .asid       (asid_i),
    .dr6        (dr6_i),
    .dr7        (dr7_i),
    .map_a_base (map_a_base_i),
    .map_b_base (map_b_base_i),
    .pa_width   (pa_width_i),
    .fail       (addr_fail)
  );

  assign fail_now = {addr_fail, mode_fail};

  gsc_verdict_reg u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .fail_now (fail_now),
    .ok       (entry_ok_o),
    .bad      (entry_bad_o),
    .fail_vec (fail_vec_o)
  );

  // Port-level rule checks across the result register
  p_virt_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !xfeat_i[VE_BIT]) |=> (entry_bad_o && fail_vec_o[RI_VIRT_OFF]));
  p_lm_nocap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && xfeat_i[LME_BIT] && !lm_cap_i) |=> fail_vec_o[RI_LM_NOCAP]);
  p_cr3_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !xfeat_i[LMA_BIT]) |=> !fail_vec_o[RI_CR3_WIDE]);
  p_asid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && asid_i == 32'd0) |=> (entry_bad_o && fail_vec_o[RI_ASID_ZERO]));
  p_long_needs_pg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cr0_i[31]) |=> !(fail_vec_o[RI_NO_PAE] || fail_vec_o[RI_NO_PE]));

endmodule

// File: tb/guest_entry_checker_test.sv
module guest_entry_checker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] xfeat_i, cr0_i, cr3_i, cr4_i, dr6_i, dr7_i;
  logic        cs_long_i, cs_dflt_i, lm_cap_i;
  logic [31:0] asid_i;
  logic [63:0] map_a_base_i, map_b_base_i;
  logic [5:0]  pa_width_i;
  logic        entry_ok_o, entry_bad_o;
  logic [13:0] fail_vec_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  guest_entry_checker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .xfeat_i(xfeat_i), .cr0_i(cr0_i), .cr3_i(cr3_i), .cr4_i(cr4_i),
    .dr6_i(dr6_i), .dr7_i(dr7_i), .cs_long_i(cs_long_i), .cs_dflt_i(cs_dflt_i),
    .lm_cap_i(lm_cap_i), .asid_i(asid_i), .map_a_base_i(map_a_base_i),
    .map_b_base_i(map_b_base_i), .pa_width_i(pa_width_i),
    .entry_ok_o(entry_ok_o), .entry_bad_o(entry_bad_o), .fail_vec_o(fail_vec_o)
  );

  task automatic check(input bit cond, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Legal long-mode state: enable bit 12, LME bit 8, LMA bit 10
  task automatic set_legal();
    xfeat_i      = 64'h1500;
    cr0_i        = 64'h8000_0001;
    cr3_i        = 64'h1000;
    cr4_i        = 64'h20;
    dr6_i        = 64'hFFFF_0FF0;
    dr7_i        = 64'h400;
    cs_long_i    = 1'b1;
    cs_dflt_i    = 1'b0;
    lm_cap_i     = 1'b1;
    asid_i       = 32'd1;
    map_a_base_i = 64'h0;
    map_b_base_i = 64'h0;
    pa_width_i   = 6'd48;
  endtask

  // Pulse start, then check verdict one cycle later and hold one more cycle
  task automatic run_entry(input string req, input logic [13:0] exp);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(fail_vec_o == exp, req, 64'(fail_vec_o), 64'(exp));
    check(entry_ok_o == (exp == 14'd0) && entry_bad_o == (exp != 14'd0),
          {req, " R10 verdict"}, {62'd0, entry_ok_o, entry_bad_o},
          {62'd0, exp == 14'd0, exp != 14'd0});
    @(negedge clk);
    check(!entry_ok_o && !entry_bad_o, "R10 pulse drop",
          {62'd0, entry_ok_o, entry_bad_o}, 64'd0);
    check(fail_vec_o == exp, "R11 hold", 64'(fail_vec_o), 64'(exp));
  endtask

  task automatic t_reset();
    check(!entry_ok_o && !entry_bad_o && fail_vec_o == 14'd0, "R11 reset",
          {48'd0, fail_vec_o, entry_ok_o, entry_bad_o}, 64'd0);
  endtask

  task automatic t_legal();
    set_legal(); run_entry("R11 legal", 14'd0);
    pa_width_i = 6'd32; run_entry("R11 legal w32", 14'd0);
    set_legal();
  endtask

  task automatic t_feature();
    set_legal(); xfeat_i[12] = 1'b0; run_entry("R1 enable clear", 14'h0001);
    set_legal(); xfeat_i[1] = 1'b1;  run_entry("R1 reserved bit1", 14'h0002);
    set_legal(); xfeat_i[40] = 1'b1; run_entry("R1 reserved bit40", 14'h0002);
    set_legal(); xfeat_i[11] = 1'b1; run_entry("R1 non-reserved bit11", 14'h0000);
    set_legal(); xfeat_i[12] = 1'b0; xfeat_i[3] = 1'b1;
    run_entry("R1 both rules", 14'h0003);
  endtask

  task automatic t_lmcap();
    set_legal(); lm_cap_i = 1'b0; run_entry("R2 no capability", 14'h0004);
    set_legal(); lm_cap_i = 1'b0; xfeat_i = 64'h1000;
    run_entry("R2 legacy mode ok", 14'h0000);
    set_legal(); lm_cap_i = 1'b0; xfeat_i = 64'h1400;
    run_entry("R2 active only", 14'h0004);
  endtask

  task automatic t_paging();
    set_legal(); cr4_i = 64'h0; run_entry("R3 no PAE", 14'h0008);
    set_legal(); cr0_i = 64'h8000_0000; run_entry("R3 no PE", 14'h0010);
    set_legal(); cr0_i = 64'h8000_0000; cr4_i = 64'h0;
    run_entry("R3 both", 14'h0018);
    set_legal(); cr0_i = 64'h0; cr4_i = 64'h0; run_entry("R3 paging off", 14'h0000);
  endtask

  task automatic t_cs();
    set_legal(); cs_dflt_i = 1'b1; run_entry("R4 L and DB", 14'h0020);
    set_legal(); cs_dflt_i = 1'b1; xfeat_i = 64'h1000;
    run_entry("R4 no long enable", 14'h0000);
    set_legal(); cs_long_i = 1'b0; cs_dflt_i = 1'b1; run_entry("R4 DB only", 14'h0000);
  endtask

  task automatic t_cr0();
    set_legal(); cr0_i[40] = 1'b1; run_entry("R5 CR0 reserved", 14'h0040);
    set_legal(); cr0_i[29] = 1'b1; run_entry("R5 NW without CD", 14'h0080);
    set_legal(); cr0_i[29] = 1'b1; cr0_i[30] = 1'b1; run_entry("R5 NW with CD", 14'h0000);
  endtask

  task automatic t_cr3();
    set_legal(); pa_width_i = 6'd40; cr3_i = 64'h100_0000_0000;
    run_entry("R6 at width", 14'h0100);
    set_legal(); pa_width_i = 6'd40; cr3_i = 64'h080_0000_0000;
    run_entry("R6 below width", 14'h0000);
    set_legal(); pa_width_i = 6'd40; cr3_i = 64'h100_0000_0000; xfeat_i = 64'h1100;
    run_entry("R6 not active", 14'h0000);
    set_legal(); pa_width_i = 6'd52; cr3_i = 64'h0010_0000_0000_0000;
    run_entry("R6 width52 edge", 14'h0100);
    set_legal(); pa_width_i = 6'd52; cr3_i = 64'h0008_0000_0000_0000;
    run_entry("R6 width52 inside", 14'h0000);
  endtask

  task automatic t_asid_dr();
    set_legal(); asid_i = 32'd0; run_entry("R7 asid zero", 14'h0200);
    set_legal(); asid_i = 32'hFFFF_FFFF; run_entry("R7 asid max", 14'h0000);
    set_legal(); dr6_i[32] = 1'b1; run_entry("R8 DR6 reserved", 14'h0400);
    set_legal(); dr7_i[63] = 1'b1; run_entry("R8 DR7 reserved", 14'h0800);
  endtask

  task automatic t_maps();
    set_legal(); pa_width_i = 6'd32;
    map_a_base_i = 64'hFFFF_DFFF; run_entry("R9 map A just inside", 14'h0000);
    map_a_base_i = 64'hFFFF_E000; run_entry("R9 map A at limit", 14'h1000);
    map_a_base_i = 64'h0;
    map_b_base_i = 64'hFFFF_CFFF; run_entry("R9 map B just inside", 14'h0000);
    map_b_base_i = 64'hFFFF_D000; run_entry("R9 map B at limit", 14'h2000);
    map_a_base_i = 64'h1_0000_0000; run_entry("R9 both maps", 14'h3000);
    set_legal();
  endtask

  task automatic t_no_start();
    set_legal(); asid_i = 32'd0; run_entry("R11 before idle", 14'h0200);
    asid_i = 32'd5; cr0_i[40] = 1'b1;
    repeat (3) @(negedge clk);
    check(!entry_ok_o && !entry_bad_o, "R10 idle no pulse",
          {62'd0, entry_ok_o, entry_bad_o}, 64'd0);
    check(fail_vec_o == 14'h0200, "R11 idle hold", 64'(fail_vec_o), 64'h200);
  endtask

  initial begin
    set_legal();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_legal();
    t_feature();
    t_lmcap();
    t_paging();
    t_cs();
    t_cr0();
    t_cr3();
    t_asid_dr();
    t_maps();
    t_no_start();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule